// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

The engine serves several independent descriptor rings held in system memory on behalf of a network controller's transmit or receive path. Each ring is a contiguous array of 16-byte descriptors at a programmable base address with a programmable slot count. Software fills descriptors starting at the first free slot and then moves the ring's head index forward. The engine owns the tail index. For every slot between tail and head it reads the descriptor, issues one payload transfer and writes the descriptor's control word back with the done flag set. It then moves the tail forward by one. A ring is fully processed once the tail equals the head. Both indices wrap to zero after the last slot. Software keeps one slot unused, so a head equal to the tail always means an empty ring.

A descriptor is two 64-bit words. The word at offset 0 holds the payload buffer address. The word at offset 8 holds control: bits 15:0 are the length, bit 16 is end-of-packet, bit 17 is done and bit 18 requests an interrupt. A packet may occupy a single descriptor or a run of consecutive descriptors, and only the last of them carries end-of-packet. On receive, software pre-posts empty buffers by raising the head. The payload side then returns the length it actually filled, and the engine writes that length back. Queues that have work are served in rotation, one descriptor per turn.

Registers are reached through a simple port. A write selects a queue and a field; reads of the selected field are combinational. The field codes are 0 for base, 1 for size, 2 for head and 3 for tail; the tail can only be read.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, every queue reads base 0, size MAX_SLOTS, head 0 and tail 0. No memory request, payload request or interrupt is active.
- R2: The descriptor in slot t of a queue with base B is fetched with two reads: first address B+16t (buffer address), then address B+16t+8 (control word).
- R3: Each descriptor produces exactly one payload request. The request carries the queue number, the 64-bit buffer address, control bits 15:0 as length and control bit 16 as end-of-packet. It is held stable until it is acknowledged.
- R4: After the payload acknowledge, the engine writes address B+16t+8 with the fetched control word, changed in two places: bit 17 is set and bits 15:0 carry the length returned with the acknowledge. No write happens before that acknowledge.
- R5: The tail advances by exactly one per consumed descriptor and wraps from size-1 to 0. Processing stops when tail equals head, and no memory request is made while all queues are empty.
- R6: A head write with a value not below the queue's size is ignored. A size write outside 2..MAX_SLOTS is ignored. The tail field cannot be written.
- R7: A valid size write sets that queue's head and tail to 0.
- R8: When several queues have pending descriptors, they are served in round-robin order by queue number, one descriptor per turn. The first turn after reset goes to queue 0.
- R9: irq_o[q] pulses for one cycle in the cycle in which queue q's tail has just advanced past a descriptor whose control bit 18 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_q_i | input | QW | Queue select for register access |
| reg_sel_i | input | 2 | Field select: 0 base, 1 size, 2 head, 3 tail |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Selected field, zero-extended |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Byte address of the 64-bit word |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| xfer_req_o | output | 1 | Payload transfer request |
| xfer_q_o | output | QW | Queue of the transfer |
| xfer_addr_o | output | 64 | Payload buffer address |
| xfer_len_o | output | 16 | Descriptor length |
| xfer_eop_o | output | 1 | Last descriptor of the packet |
| xfer_ack_i | input | 1 | Transfer finished |
| xfer_len_i | input | 16 | Length actually moved, written back |
| irq_o | output | NQ | Per-queue interrupt pulse |

## Verification
The assertions take for granted that a memory read returns exactly one rvalid for each granted read, after the grant and before the next request. They also assume that software never rewrites a queue's size while that queue is being served, and never advances a head past the unused slot. The bench's memory model answers every accepted read on the following cycle and inserts random grant and acknowledge stalls. It reprograms a size only when all tails have caught up with their heads, and it never posts more than size-1 descriptors ahead of the tail.

// File: rtl/drq_pkg.sv
`timescale 1ns/1ps
package drq_pkg;
  localparam int DESC_SHIFT = 4;
  localparam int LEN_W      = 16;
  localparam int EOP_BIT    = 16;
  localparam int DONE_BIT   = 17;
  localparam int IRQ_BIT    = 18;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_HEAD = 2'd2,
    SEL_TAIL = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WT_ADDR,
    ST_RD_CTRL,
    ST_WT_CTRL,
    ST_XFER,
    ST_WB
  } eng_state_e;
endpackage

// File: rtl/drq_regs.sv
`timescale 1ns/1ps
module drq_regs import drq_pkg::*; #(
  parameter int NQ        = 3,
  parameter int MAX_SLOTS = 256,
  parameter int AW        = 32,
  parameter int QW        = 2,
  parameter int IW        = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [QW-1:0]          reg_q_i,
  input  logic [1:0]             reg_sel_i,
  input  logic [AW-1:0]          reg_wdata_i,
  output logic [AW-1:0]          reg_rdata_o,
  input  logic                   adv_i,
  input  logic [QW-1:0]          adv_q_i,
  output logic [NQ-1:0][AW-1:0]  base_o,
  output logic [NQ-1:0][IW-1:0]  tail_o,
  output logic [NQ-1:0]          pending_o
);
  localparam int SW = $clog2(MAX_SLOTS + 1);

  logic [NQ-1:0][SW-1:0] size_w;
  logic [NQ-1:0][IW-1:0] head_w;
  reg_sel_e sel;
  logic size_ok;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign size_ok = (reg_wdata_i >= AW'(2)) && (reg_wdata_i <= AW'(MAX_SLOTS));

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [AW-1:0] base_r;
    logic [SW-1:0] size_r;
    logic [IW-1:0] head_r, tail_r, tail_nxt;
    logic          hit, head_ok;

    assign hit      = reg_we_i && (reg_q_i == QW'(g));
    assign head_ok  = reg_wdata_i < AW'(size_r);
    assign tail_nxt = (SW'(tail_r) == size_r - SW'(1)) ? '0 : tail_r + IW'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_r <= '0;
        size_r <= SW'(MAX_SLOTS);
        head_r <= '0;
        tail_r <= '0;
      end else begin
        if (hit && sel == SEL_BASE) base_r <= reg_wdata_i;
        if (hit && sel == SEL_SIZE && size_ok) begin
          size_r <= reg_wdata_i[SW-1:0];
          head_r <= '0;
          tail_r <= '0;
        end else begin
          if (hit && sel == SEL_HEAD && head_ok) head_r <= reg_wdata_i[IW-1:0];
          if (adv_i && adv_q_i == QW'(g)) tail_r <= tail_nxt;
        end
      end
    end

    assign base_o[g]    = base_r;
    assign tail_o[g]    = tail_r;
    assign size_w[g]    = size_r;
    assign head_w[g]    = head_r;
    assign pending_o[g] = head_r != tail_r;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_q_i) < NQ) begin
      unique case (sel)
        SEL_BASE: reg_rdata_o = base_o[reg_q_i];
        SEL_SIZE: reg_rdata_o = AW'(size_w[reg_q_i]);
        SEL_HEAD: reg_rdata_o = AW'(head_w[reg_q_i]);
        SEL_TAIL: reg_rdata_o = AW'(tail_o[reg_q_i]);
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/drq_rr_arb.sv
`timescale 1ns/1ps
module drq_rr_arb #(
  parameter int NQ = 3,
  parameter int QW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] req_i,
  input  logic          take_i,
  output logic [NQ-1:0] gnt_o,
  output logic [QW-1:0] idx_o,
  output logic          valid_o
);
  logic [QW-1:0] last_q;
  int c;

  // search starts one past the queue served last
  always_comb begin
    gnt_o   = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    c       = 0;
    for (int off = 1; off <= NQ; off++) begin
      c = int'(last_q) + off;
      if (c >= NQ) c = c - NQ;
      if (!valid_o && req_i[c]) begin
        valid_o  = 1'b1;
        idx_o    = QW'(c);
        gnt_o[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= QW'(NQ - 1);
    else if (take_i) last_q <= idx_o;
  end
endmodule

// File: rtl/drq_seq.sv
`timescale 1ns/1ps
module drq_seq import drq_pkg::*; #(
  parameter int NQ = 3,
  parameter int AW = 32,
  parameter int QW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_valid_i,
  input  logic [QW-1:0]    gnt_idx_i,
  input  logic [AW-1:0]    start_addr_i,
  output logic             take_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             xfer_req_o,
  output logic [QW-1:0]    xfer_q_o,
  output logic [63:0]      xfer_addr_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic             xfer_eop_o,
  input  logic             xfer_ack_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  output logic             adv_o,
  output logic [QW-1:0]    adv_q_o,
  output logic [NQ-1:0]    irq_o
);
  eng_state_e       state_q;
  logic [QW-1:0]    q_q;
  logic [AW-1:0]    daddr_q;
  logic [63:0]      buf_q, ctl_q;
  logic [LEN_W-1:0] rlen_q;
  logic [NQ-1:0]    irq_q;

  always_comb begin
    take_o      = (state_q == ST_IDLE) && gnt_valid_i;
    mem_req_o   = (state_q == ST_RD_ADDR) || (state_q == ST_RD_CTRL) || (state_q == ST_WB);
    mem_we_o    = state_q == ST_WB;
    mem_addr_o  = (state_q == ST_RD_ADDR) ? daddr_q : daddr_q + AW'(8);
    mem_wdata_o = {ctl_q[63:IRQ_BIT], 1'b1, ctl_q[EOP_BIT], rlen_q};
    xfer_req_o  = state_q == ST_XFER;
    xfer_q_o    = q_q;
    xfer_addr_o = buf_q;
    xfer_len_o  = ctl_q[LEN_W-1:0];
    xfer_eop_o  = ctl_q[EOP_BIT];
    adv_o       = (state_q == ST_WB) && mem_gnt_i;
    adv_q_o     = q_q;
    irq_o       = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      q_q     <= '0;
      daddr_q <= '0;
      buf_q   <= '0;
      ctl_q   <= '0;
      rlen_q  <= '0;
      irq_q   <= '0;
    end else begin
      irq_q <= '0;
      unique case (state_q)
        ST_IDLE: if (gnt_valid_i) begin
          q_q     <= gnt_idx_i;
          daddr_q <= start_addr_i;
          state_q <= ST_RD_ADDR;
        end
        ST_RD_ADDR: if (mem_gnt_i) state_q <= ST_WT_ADDR;
        ST_WT_ADDR: if (mem_rvalid_i) begin
          buf_q   <= mem_rdata_i;
          state_q <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (mem_gnt_i) state_q <= ST_WT_CTRL;
        ST_WT_CTRL: if (mem_rvalid_i) begin
          ctl_q   <= mem_rdata_i;
          state_q <= ST_XFER;
        end
        ST_XFER: if (xfer_ack_i) begin
          rlen_q  <= xfer_len_i;
          state_q <= ST_WB;
        end
        ST_WB: if (mem_gnt_i) begin
          if (ctl_q[IRQ_BIT]) irq_q[q_q] <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_ring_engine.sv
`timescale 1ns/1ps
module desc_ring_engine import drq_pkg::*; #(
  parameter int NQ        = 3,
  parameter int MAX_SLOTS = 256,
  parameter int AW        = 32,
  localparam int QW       = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [QW-1:0]    reg_q_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [AW-1:0]    reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             xfer_req_o,
  output logic [QW-1:0]    xfer_q_o,
  output logic [63:0]      xfer_addr_o,
  output logic [15:0]      xfer_len_o,
  output logic             xfer_eop_o,
  input  logic             xfer_ack_i,
  input  logic [15:0]      xfer_len_i,
  output logic [NQ-1:0]    irq_o
);
  localparam int IW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  logic [NQ-1:0][AW-1:0] base_w;
  logic [NQ-1:0][IW-1:0] tail_w;
  logic [NQ-1:0]         pending_w, gnt_w;
  logic [QW-1:0]         gnt_idx_w, adv_q_w;
  logic                  gnt_valid_w, take_w, adv_w;
  logic [AW-1:0]         start_addr_w;

  assign start_addr_w = base_w[gnt_idx_w] + (AW'(tail_w[gnt_idx_w]) << DESC_SHIFT);

  drq_regs #(.NQ(NQ), .MAX_SLOTS(MAX_SLOTS), .AW(AW), .QW(QW), .IW(IW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_q_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .adv_i(adv_w), .adv_q_i(adv_q_w), .base_o(base_w), .tail_o(tail_w),
    .pending_o(pending_w)
  );

  drq_rr_arb #(.NQ(NQ), .QW(QW)) u_arb (
    .clk_i, .rst_ni, .req_i(pending_w), .take_i(take_w),
    .gnt_o(gnt_w), .idx_o(gnt_idx_w), .valid_o(gnt_valid_w)
  );

  drq_seq #(.NQ(NQ), .AW(AW), .QW(QW)) u_seq (
    .clk_i, .rst_ni, .gnt_valid_i(gnt_valid_w), .gnt_idx_i(gnt_idx_w),
    .start_addr_i(start_addr_w), .take_o(take_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rvalid_i,
    .mem_rdata_i, .xfer_req_o, .xfer_q_o, .xfer_addr_o, .xfer_len_o, .xfer_eop_o,
    .xfer_ack_i, .xfer_len_i, .adv_o(adv_w), .adv_q_o(adv_q_w), .irq_o
  );
endmodule

// File: rtl/drq_checker.sv
`timescale 1ns/1ps
module drq_checker #(
  parameter int NQ = 3,
  parameter int IW = 8,
  parameter int AW = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  mem_req_o,
  input logic                  mem_we_o,
  input logic [AW-1:0]         mem_addr_o,
  input logic                  mem_gnt_i,
  input logic                  xfer_req_o,
  input logic                  xfer_ack_i,
  input logic [63:0]           xfer_addr_o,
  input logic [15:0]           xfer_len_o,
  input logic [NQ-1:0]         irq_o,
  input logic [NQ-1:0][IW-1:0] tail_i,
  input logic [NQ-1:0]         gnt_i
);
  a_r2_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r3_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_ack_i |=> xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o));

  a_r3_phase_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_req_o));

  a_r4_wb_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o && mem_we_o) |-> $past(xfer_req_o && xfer_ack_i));

  a_r8_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  for (genvar g = 0; g < NQ; g++) begin : g_q
    a_r5_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_i[g] != $past(tail_i[g]) |-> tail_i[g] == '0 || tail_i[g] == $past(tail_i[g]) + IW'(1));

    a_r9_irq_on_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> tail_i[g] != $past(tail_i[g]));
  end
endmodule

bind desc_ring_engine drq_checker #(.NQ(NQ), .IW(IW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .xfer_req_o(xfer_req_o),
  .xfer_ack_i(xfer_ack_i), .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
  .irq_o(irq_o), .tail_i(tail_w), .gnt_i(gnt_w)
);

// File: tb/desc_ring_engine_bench.sv
`timescale 1ns/1ps
module desc_ring_engine_bench;
  import drq_pkg::*;
  localparam int NQ = 3, AW = 32, MAXS = 256, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic reg_we; logic [QW-1:0] reg_q; logic [1:0] reg_sel;
  logic [AW-1:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr; logic [63:0] mem_wdata, mem_rdata;
  logic xfer_req, xfer_eop, xfer_ack; logic [QW-1:0] xfer_q;
  logic [63:0] xfer_addr; logic [15:0] xfer_len, xfer_rlen;
  logic [NQ-1:0] irq;

  desc_ring_engine #(.NQ(NQ), .MAX_SLOTS(MAXS), .AW(AW)) u_desc_ring_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_q_i(reg_q), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .xfer_req_o(xfer_req),
    .xfer_q_o(xfer_q), .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len), .xfer_eop_o(xfer_eop),
    .xfer_ack_i(xfer_ack), .xfer_len_i(xfer_rlen), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  logic [63:0] mem [0:4095];
  bit stall_en = 1'b0;
  int n_rd, n_wr, n_xf, n_req;
  int irq_cnt [NQ];
  logic [AW-1:0] rd_log [64], wr_addr [64];
  logic [63:0] wr_data [64], xf_addr [64];
  int xf_q [64]; logic [15:0] xf_len [64]; logic xf_eop [64];

  int m_tail [NQ], m_size [NQ], m_last;
  logic [AW-1:0] d_addr [NQ][8];
  logic [63:0] d_buf [NQ][8], d_ctl [NQ][8];
  int e_q [64], e_i [64], e_n;

  function automatic logic [15:0] rx_len(input logic [15:0] l);
    return l ^ 16'h0F0F;
  endfunction

  function automatic logic [AW-1:0] qbase(input int q);
    return AW'(32'h1000 * (q + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int q, input logic [1:0] sel, input logic [AW-1:0] d);
    reg_q = QW'(q); reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int q, input logic [1:0] sel, output logic [AW-1:0] v);
    reg_q = QW'(q); reg_sel = sel;
    #0.5;
    v = reg_rdata;
  endtask

  // memory and payload responder
  initial begin
    logic rd_pend; logic [11:0] rd_idx;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; xfer_ack = 0; xfer_rlen = '0;
    rd_pend = 0; rd_idx = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        mem_rvalid = 1'b1; mem_rdata = mem[rd_idx]; rd_pend = 1'b0;
      end
      mem_gnt = 1'b0;
      if (mem_req) begin
        n_req++;
        if (!stall_en || ($urandom % 3 != 0)) begin
          mem_gnt = 1'b1;
          if (mem_we) begin
            mem[mem_addr[14:3]] = mem_wdata;
            if (n_wr < 64) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
            n_wr++;
          end else begin
            rd_pend = 1'b1; rd_idx = mem_addr[14:3];
            if (n_rd < 64) rd_log[n_rd] = mem_addr;
            n_rd++;
          end
        end
      end
      xfer_ack = 1'b0;
      if (xfer_req && (!stall_en || ($urandom % 2 == 0))) begin
        xfer_ack = 1'b1; xfer_rlen = rx_len(xfer_len);
        if (n_xf < 64) begin
          xf_q[n_xf] = int'(xfer_q); xf_addr[n_xf] = xfer_addr;
          xf_len[n_xf] = xfer_len; xf_eop[n_xf] = xfer_eop;
        end
        n_xf++;
      end
      for (int q = 0; q < NQ; q++) if (irq[q]) irq_cnt[q]++;
    end
  end

  task automatic scenario(input int c0, input int c1, input int c2);
    int cnt [NQ]; int rem [NQ]; int pos [NQ]; int exp_irq [NQ];
    int first, any; logic [AW-1:0] v; bit done;
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
    n_rd = 0; n_wr = 0; n_xf = 0; e_n = 0;
    for (int q = 0; q < NQ; q++) begin
      irq_cnt[q] = 0; exp_irq[q] = 0; rem[q] = cnt[q]; pos[q] = 0;
      for (int i = 0; i < cnt[q]; i++) begin
        int slot; logic [63:0] ctl;
        slot = (m_tail[q] + i) % m_size[q];
        d_addr[q][i] = qbase(q) + AW'(slot * 16);
        d_buf[q][i] = {$urandom, $urandom};
        ctl = {$urandom, $urandom};
        ctl[16] = (i == cnt[q] - 1) || ($urandom % 3 == 0);
        ctl[17] = 1'b0;
        if (ctl[18]) exp_irq[q]++;
        d_ctl[q][i] = ctl;
        mem[d_addr[q][i][14:3]] = d_buf[q][i];
        mem[d_addr[q][i][14:3] + 12'd1] = ctl;
      end
    end
    first = m_last;
    any = 1;
    while (any != 0) begin
      any = 0;
      for (int off = 1; off <= NQ; off++) begin
        int c; c = (m_last + off) % NQ;
        if (any == 0 && rem[c] > 0) begin
          e_q[e_n] = c; e_i[e_n] = pos[c]; e_n++;
          pos[c]++; rem[c]--; m_last = c; any = 1;
        end
      end
    end
    for (int off = 1; off <= NQ; off++) begin
      int q; q = (first + off) % NQ;
      if (cnt[q] > 0) wr(q, SEL_HEAD, AW'((m_tail[q] + cnt[q]) % m_size[q]));
    end
    for (int q = 0; q < NQ; q++) m_tail[q] = (m_tail[q] + cnt[q]) % m_size[q];
    done = 0;
    for (int w = 0; w < 4000 && !done; w++) begin
      @(negedge clk);
      done = 1;
      for (int q = 0; q < NQ; q++) begin
        rd(q, SEL_TAIL, v);
        if (v != AW'(m_tail[q])) done = 0;
      end
    end
    repeat (4) @(negedge clk);
    chk(n_xf == e_n, "R3", "transfer count", 64'(n_xf), 64'(e_n));
    chk(n_rd == 2 * e_n, "R2", "read count", 64'(n_rd), 64'(2 * e_n));
    chk(n_wr == e_n, "R4", "write count", 64'(n_wr), 64'(e_n));
    for (int k = 0; k < e_n && k < n_xf && 2 * k + 1 < n_rd && k < n_wr; k++) begin
      int q, i; logic [63:0] wb;
      q = e_q[k]; i = e_i[k];
      wb = d_ctl[q][i]; wb[17] = 1'b1; wb[15:0] = rx_len(d_ctl[q][i][15:0]);
      chk(xf_q[k] == q, "R8", "service order", 64'(xf_q[k]), 64'(q));
      chk(xf_addr[k] == d_buf[q][i], "R3", "buffer addr", xf_addr[k], d_buf[q][i]);
      chk(xf_len[k] == d_ctl[q][i][15:0], "R3", "length", 64'(xf_len[k]), 64'(d_ctl[q][i][15:0]));
      chk(xf_eop[k] == d_ctl[q][i][16], "R3", "eop", 64'(xf_eop[k]), 64'(d_ctl[q][i][16]));
      chk(rd_log[2*k] == d_addr[q][i], "R2", "addr word read", 64'(rd_log[2*k]), 64'(d_addr[q][i]));
      chk(rd_log[2*k+1] == d_addr[q][i] + 8, "R2", "ctrl word read",
          64'(rd_log[2*k+1]), 64'(d_addr[q][i] + 8));
      chk(wr_addr[k] == d_addr[q][i] + 8, "R4", "writeback addr",
          64'(wr_addr[k]), 64'(d_addr[q][i] + 8));
      chk(wr_data[k] == wb, "R4", "writeback data", wr_data[k], wb);
    end
    for (int q = 0; q < NQ; q++) begin
      rd(q, SEL_TAIL, v);
      chk(v == AW'(m_tail[q]), "R5", "tail after run", 64'(v), 64'(m_tail[q]));
      chk(irq_cnt[q] == exp_irq[q], "R9", "irq pulses", 64'(irq_cnt[q]), 64'(exp_irq[q]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    void'($urandom(32'd4242));
    reg_we = 0; reg_q = '0; reg_sel = '0; reg_wdata = '0;
    n_rd = 0; n_wr = 0; n_xf = 0; n_req = 0;
    for (int q = 0; q < NQ; q++) irq_cnt[q] = 0;
    m_size[0] = 5; m_size[1] = 4; m_size[2] = 7; m_last = NQ - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !xfer_req, "R1", "idle requests", {mem_req, xfer_req}, 0);
    chk(irq == '0, "R1", "irq", 64'(irq), 0);
    for (int q = 0; q < NQ; q++) begin
      rd(q, SEL_BASE, v); chk(v == 0, "R1", "base", 64'(v), 0);
      rd(q, SEL_SIZE, v); chk(v == MAXS, "R1", "size", 64'(v), MAXS);
      rd(q, SEL_HEAD, v); chk(v == 0, "R1", "head", 64'(v), 0);
      rd(q, SEL_TAIL, v); chk(v == 0, "R1", "tail", 64'(v), 0);
    end
    // preload the head so the size write must clear it (R7)
    wr(0, SEL_HEAD, 32'd9);
    @(negedge clk);
    wait (!mem_req && !xfer_req);
    repeat (60) @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      wr(q, SEL_BASE, qbase(q));
      wr(q, SEL_SIZE, AW'(m_size[q]));
      rd(q, SEL_HEAD, v); chk(v == 0, "R7", "head after size write", 64'(v), 0);
      rd(q, SEL_TAIL, v); chk(v == 0, "R7", "tail after size write", 64'(v), 0);
      rd(q, SEL_SIZE, v); chk(v == AW'(m_size[q]), "R7", "size value", 64'(v), 64'(m_size[q]));
      m_tail[q] = 0;
    end
    // traffic from the preload is discarded; restart the rotation model from its last queue
    m_last = 0;
    wr(0, SEL_SIZE, 32'd1);
    rd(0, SEL_SIZE, v); chk(v == 5, "R6", "size 1 ignored", 64'(v), 5);
    wr(0, SEL_SIZE, AW'(MAXS + 1));
    rd(0, SEL_SIZE, v); chk(v == 5, "R6", "oversize ignored", 64'(v), 5);
    wr(0, SEL_HEAD, 32'd5);
    rd(0, SEL_HEAD, v); chk(v == 0, "R6", "head >= size ignored", 64'(v), 0);
    wr(1, SEL_TAIL, 32'd2);
    rd(1, SEL_TAIL, v); chk(v == 0, "R6", "tail not writable", 64'(v), 0);
    n_req = 0;
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R5", "no requests when empty", 64'(n_req), 0);
    scenario(4, 3, 6);
    stall_en = 1'b1;
    scenario(4, 3, 6);
    scenario(1, 0, 2);
    for (int r = 0; r < 12; r++)
      scenario(int'($urandom % 5), int'($urandom % 4), int'($urandom % 7));
    wr(1, SEL_SIZE, 32'd4);
    rd(1, SEL_TAIL, v); chk(v == 0, "R7", "tail cleared after traffic", 64'(v), 0);
    rd(1, SEL_HEAD, v); chk(v == 0, "R7", "head cleared after traffic", 64'(v), 0);
    m_tail[1] = 0;
    scenario(3, 3, 3);
    n_req = 0;
    repeat (30) @(negedge clk);
    chk(n_req == 0, "R5", "quiet after completion", 64'(n_req), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule